// File: doc/BRIEF.md
# Ratiometric Dual-Oscillator Conversion Counter

This block turns the frequency ratio of two free-running oscillator signals into one digital code. It needs no system timebase. The reference oscillator sets the length of the measurement window. The other oscillator, the measurement signal, is counted over that window. A conversion starts when a start pulse arrives in the readout clock domain. The reference domain then opens a gate that stays open for a programmable number of reference periods. The measurement domain counts its own edges while the gate is open. The final count is passed back to the readout domain together with a done flag.

The result equals the terminal count multiplied by f_meas / f_ref. This is a ratio, so a disturbance that slows or speeds both oscillators together cancels out of the code. Every signal that crosses between the three domains passes through a two-flop synchronizer. The two ends of the window are delayed by the same synchronizer latency, so that delay largely cancels.

Typical use is a temperature sensing loop. The reference is the ring with the flatter thermal slope, near 20 MHz. The terminal count is around 16000, which gives a conversion of roughly 0.8 ms. A longer terminal count gives a finer code step, at the cost of a longer conversion.

Top module: `osc_ratio_counter`

## Requirements
- R1: After reset, `busy`, `done` and `ovf` are 0 and `code` is 0.
- R2: A `start` high at a `rd_clk` edge while `busy` is 0 is accepted. In the next cycle `busy` is 1 and `done` is 0.
- R3: If the count does not saturate, the final `code` equals round(L × f_meas / f_ref) within ±2 counts, where L is the effective terminal count.
- R4: The terminal count is taken from `term` at the accepted start and holds for the whole conversion. A `term` of 0 is treated as 1.
- R5: The 14-bit measurement count saturates at 16383 instead of wrapping. When it saturates, `ovf` is 1 and `code` is 16383. Otherwise `ovf` is 0.
- R6: A `start` that arrives while `busy` is 1 is ignored. It neither restarts the conversion nor changes its terminal count, and each accepted start produces exactly one completion.
- R7: At completion, `done` rises in the same cycle that `busy` falls. `code` and `ovf` change only in that cycle. `done` then stays 1 until the next accepted start.
- R8: The time from the accepted start to `done` is at least L reference periods. It is at most L + 4 reference periods, plus 4 measurement periods, plus 6 `rd_clk` periods.
- R9: Every conversion counts from zero, so a result does not depend on any earlier conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all three domains |
| rd_clk | input | 1 | Readout clock |
| ref_osc | input | 1 | Reference oscillator; its edges set the window |
| meas_osc | input | 1 | Measurement oscillator; its edges are counted |
| start | input | 1 | Conversion request, sampled on `rd_clk` |
| term | input | 14 | Terminal reference count, captured at start |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Result valid, held until next accepted start |
| code | output | 14 | Measurement count of the last conversion |
| ovf | output | 1 | Last conversion saturated |

## Verification
Suppose the gate or a counter is left in a wrong state. A stale reference counter or a missed clear shows up in the next `code` as a value far from the ratio the bench computes. This happens on the first conversion after the fault. A broken toggle handshake shows up as `busy` never falling, so the bench's completion timeout fails within one window length. It can also show up as a second, unrequested completion, which appears at the ports within a few `rd_clk` cycles. Wrong saturation shows up as a wrapped small `code`, or as `ovf` disagreeing with `code`, on the overflow case.

// File: rtl/osc_ratio_pkg.sv
package osc_ratio_pkg;
    parameter int unsigned CNT_W_DEF   = 14;
    parameter int unsigned SYNC_N_DEF  = 2;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int unsigned STAGES = osc_ratio_pkg::SYNC_N_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/ref_window.sv
// Reference-oscillator domain: arms on a request toggle, keeps the gate
// open for max(limit,1) reference periods.
module ref_window #(
    parameter int unsigned W      = osc_ratio_pkg::CNT_W_DEF,
    parameter int unsigned SYNC_N = osc_ratio_pkg::SYNC_N_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_tgl,
    input  logic [W-1:0] limit_in,
    output logic         gate
);
    localparam int unsigned EW = W + 1;

    typedef struct packed {
        logic         req_p;
        logic         gate;
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
    } win_t;

    win_t s_d, s_q;
    logic req_s;

    bit_sync #(.STAGES(SYNC_N)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .din(req_tgl), .dout(req_s)
    );

    always_comb begin
        s_d       = s_q;
        s_d.req_p = req_s;
        if ((req_s != s_q.req_p) && !s_q.gate) begin
            s_d.gate = 1'b1;
            s_d.cnt  = '0;
            s_d.lim  = limit_in;
        end else if (s_q.gate) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if ((EW'(s_q.cnt) + EW'(1)) >= EW'(s_q.lim)) begin
                s_d.gate = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gate = s_q.gate;
endmodule

// File: rtl/meas_tally.sv
// Measurement-oscillator domain: counts edges while the synchronized gate
// is open, saturates, and toggles a finish flag when the gate closes.
module meas_tally #(
    parameter int unsigned W      = osc_ratio_pkg::CNT_W_DEF,
    parameter int unsigned SYNC_N = osc_ratio_pkg::SYNC_N_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gate_in,
    output logic [W-1:0] count,
    output logic         sat,
    output logic         fin_tgl
);
    localparam logic [W-1:0] CMAX = '1;

    typedef struct packed {
        logic         gate_p;
        logic [W-1:0] cnt;
        logic         sat;
        logic         fin;
    } tally_t;

    tally_t s_d, s_q;
    logic gate_s;

    bit_sync #(.STAGES(SYNC_N)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .din(gate_in), .dout(gate_s)
    );

    always_comb begin
        s_d        = s_q;
        s_d.gate_p = gate_s;
        if (gate_s && !s_q.gate_p) begin
            s_d.cnt = {{(W-1){1'b0}}, 1'b1};
            s_d.sat = 1'b0;
        end else if (gate_s) begin
            if (s_q.cnt == CMAX) s_d.sat = 1'b1;
            else                 s_d.cnt = s_q.cnt + 1'b1;
        end
        if (!gate_s && s_q.gate_p) begin
            s_d.fin = ~s_q.fin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign sat     = s_q.sat;
    assign fin_tgl = s_q.fin;
endmodule

// File: rtl/readout_ctrl.sv
// Readout domain: accepts start, issues the request toggle, captures the
// result when the finish toggle arrives.
module readout_ctrl #(
    parameter int unsigned W      = osc_ratio_pkg::CNT_W_DEF,
    parameter int unsigned SYNC_N = osc_ratio_pkg::SYNC_N_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] term_in,
    input  logic         fin_tgl,
    input  logic [W-1:0] cnt_in,
    input  logic         sat_in,
    output logic         req_tgl,
    output logic [W-1:0] limit,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] code,
    output logic         ovf
);
    typedef struct packed {
        logic         req;
        logic         fin_p;
        logic         busy;
        logic         done;
        logic [W-1:0] lim;
        logic [W-1:0] code;
        logic         ovf;
    } rd_t;

    rd_t s_d, s_q;
    logic fin_s;

    bit_sync #(.STAGES(SYNC_N)) u_fin_sync (
        .clk(clk), .rst_n(rst_n), .din(fin_tgl), .dout(fin_s)
    );

    always_comb begin
        s_d       = s_q;
        s_d.fin_p = fin_s;
        if (start && !s_q.busy) begin
            s_d.req  = ~s_q.req;
            s_d.busy = 1'b1;
            s_d.done = 1'b0;
            s_d.lim  = term_in;
        end else if (s_q.busy && (fin_s != s_q.fin_p)) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.code = cnt_in;
            s_d.ovf  = sat_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_tgl = s_q.req;
    assign limit   = s_q.lim;
    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign code    = s_q.code;
    assign ovf     = s_q.ovf;
endmodule

// File: rtl/osc_ratio_counter.sv
module osc_ratio_counter #(
    parameter int unsigned CNT_W  = osc_ratio_pkg::CNT_W_DEF,
    parameter int unsigned SYNC_N = osc_ratio_pkg::SYNC_N_DEF
) (
    input  logic             rst_n,
    input  logic             rd_clk,
    input  logic             ref_osc,
    input  logic             meas_osc,
    input  logic             start,
    input  logic [CNT_W-1:0] term,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] code,
    output logic             ovf
);
    logic             req_tgl;
    logic [CNT_W-1:0] limit;
    logic             gate;
    logic [CNT_W-1:0] m_count;
    logic             m_sat;
    logic             fin_tgl;

    readout_ctrl #(.W(CNT_W), .SYNC_N(SYNC_N)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .start(start), .term_in(term),
        .fin_tgl(fin_tgl), .cnt_in(m_count), .sat_in(m_sat),
        .req_tgl(req_tgl), .limit(limit), .busy(busy), .done(done),
        .code(code), .ovf(ovf)
    );

    ref_window #(.W(CNT_W), .SYNC_N(SYNC_N)) u_ref (
        .clk(ref_osc), .rst_n(rst_n), .req_tgl(req_tgl),
        .limit_in(limit), .gate(gate)
    );

    meas_tally #(.W(CNT_W), .SYNC_N(SYNC_N)) u_meas (
        .clk(meas_osc), .rst_n(rst_n), .gate_in(gate),
        .count(m_count), .sat(m_sat), .fin_tgl(fin_tgl)
    );
endmodule

// File: rtl/osc_ratio_checker.sv
module osc_ratio_checker #(
    parameter int unsigned W = 14
) (
    input logic         rd_clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] code,
    input logic         ovf
);
    assert_start_accept_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    assert_done_ends_busy_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    assert_busy_done_apart_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        busy |-> !done);

    assert_code_moves_at_done_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !$stable(code) |-> $rose(done));

    assert_ovf_moves_at_done_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !$stable(ovf) |-> $rose(done));

    assert_sat_code_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ovf |-> (code == {W{1'b1}}));
endmodule

bind osc_ratio_counter osc_ratio_checker #(.W(CNT_W)) u_chk (
    .rd_clk(rd_clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .code(code), .ovf(ovf)
);

// File: tb/osc_ratio_counter_test.sv
`timescale 1ns/1ps
module osc_ratio_counter_test;
    localparam int W = 14;
    localparam int CMAX = (1 << W) - 1;

    logic rst_n = 1'b0;
    logic rd_clk = 1'b0;
    logic ref_osc = 1'b0;
    logic meas_osc = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] term = '0;
    logic busy, done, ovf;
    logic [W-1:0] code;

    real ref_half  = 25.5;
    real meas_half = 23.8;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    osc_ratio_counter uut (
        .rst_n(rst_n), .rd_clk(rd_clk), .ref_osc(ref_osc), .meas_osc(meas_osc),
        .start(start), .term(term), .busy(busy), .done(done), .code(code), .ovf(ovf)
    );

    always #5 rd_clk = ~rd_clk;
    initial begin #3.3; forever #(ref_half) ref_osc = ~ref_osc; end
    initial begin #1.7; forever #(meas_half) meas_osc = ~meas_osc; end

    always @(posedge rd_clk) cycles <= cycles + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff_len(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int exp_code(input real tref, input real tmeas, input int t);
        real r;
        int e;
        r = eff_len(t) * tref / tmeas;
        e = $rtoi(r + 0.5);
        return (e > CMAX) ? CMAX : e;
    endfunction

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic pulse_start(input int t);
        @(negedge rd_clk);
        term  = W'(t);
        start = 1'b1;
        @(negedge rd_clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int n;
        n = 0;
        while (!done && n < 40000) begin
            @(negedge rd_clk);
            n++;
        end
        ok = done;
    endtask

    task automatic convert(input real tref, input real tmeas, input int t, input bit want_sat);
        bit ok;
        real t0, dt, lo, hi;
        int exp, held;
        ref_half  = tref / 2.0;
        meas_half = tmeas / 2.0;
        repeat (20) @(negedge rd_clk);
        t0 = $realtime;
        pulse_start(t);
        check(busy && !done, "R2 busy after start", int'(busy), 1);
        wait_done(ok);
        dt = $realtime - t0;
        check(ok, "R8 completion seen", int'(ok), 1);
        exp = exp_code(tref, tmeas, t);
        if (want_sat) begin
            check(code == W'(CMAX), "R5 saturated code", int'(code), CMAX);
            check(ovf, "R5 ovf set", int'(ovf), 1);
        end else begin
            check(absdiff(int'(code), exp) <= 2, "R3 ratio code", int'(code), exp);
            check(!ovf, "R5 ovf clear", int'(ovf), 0);
        end
        lo = eff_len(t) * tref;
        hi = lo + 4.0 * tref + 4.0 * tmeas + 60.0;
        check(dt >= lo && dt <= hi, "R8 conversion time", $rtoi(dt), $rtoi(lo));
        held = int'(code);
        repeat (30) @(negedge rd_clk);
        check(done && !busy && int'(code) == held, "R7 result held", int'(code), held);
    endtask

    initial begin
        forever begin
            @(negedge rd_clk);
            if (cycles > 195000 && !finished) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 195000);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int seed;
        bit ok;
        seed = $urandom(32'h1c0ffee);
        repeat (4) @(negedge rd_clk);
        // R1 reset values
        check(!busy, "R1 busy", int'(busy), 0);
        check(!done, "R1 done", int'(done), 0);
        check(code == '0, "R1 code", int'(code), 0);
        check(!ovf, "R1 ovf", int'(ovf), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge rd_clk);

        // R3: 19.6 MHz reference vs 21 MHz measurement
        convert(51.02, 47.62, 2000, 1'b0);
        // R4: zero treated as one, and one
        convert(50.0, 20.0, 0, 1'b0);
        convert(50.0, 20.0, 1, 1'b0);
        // R5: saturation with a fast measurement oscillator
        convert(51.0, 2.5, 1000, 1'b1);
        // R9: large then small, each counts from zero
        convert(45.0, 40.0, 1500, 1'b0);
        convert(45.0, 40.0, 150, 1'b0);

        // R6: start during a conversion is ignored
        ref_half = 25.0;
        meas_half = 15.0;
        repeat (20) @(negedge rd_clk);
        pulse_start(600);
        repeat (50) @(negedge rd_clk);
        term = W'(100);
        start = 1'b1;
        @(negedge rd_clk);
        start = 1'b0;
        check(busy, "R6 busy kept", int'(busy), 1);
        wait_done(ok);
        check(absdiff(int'(code), exp_code(50.0, 30.0, 600)) <= 2, "R6 term kept",
              int'(code), exp_code(50.0, 30.0, 600));
        repeat (300) @(negedge rd_clk);
        check(done && !busy, "R6 single completion", int'(busy), 0);

        // R3 random ratios
        for (int i = 0; i < 6; i++) begin
            real tr, tm;
            int t;
            tr = 40.0 + real'($urandom_range(200)) / 10.0;
            tm = 30.0 + real'($urandom_range(500)) / 10.0;
            t  = 100 + $urandom_range(1100);
            convert(tr, tm, t, 1'b0);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule